// File: doc/BRIEF.md
# Shift-Register Sequence Self-Test Matcher

The block checks a small captured buffer against a known pseudo-random sequence. Software or a capture engine first fills the buffer through a simple write port. A start strobe then launches the check. The block loads a fixed 64-bit seed. On every clock it compares the current sequence value with every buffer word except word 0. It adds the number of equal words to a running total, then advances the value by one step of a Galois-style shift register.

The check ends as soon as the running total reaches the goal, which signals pass. It also ends when the step limit is used up without reaching the goal, which signals fail. The step count output tells how many comparison steps were made. A passing check therefore shows how far into the sequence the captured data was found.

Top module: `lfsr_selftest_matcher`

## Requirements
- R1: After reset, busy_o, pass_o and fail_o are 0, steps_o is 0, and all buffer words are 0.
- R2: A start_i pulse while idle sets busy_o on the next cycle. In that same cycle pass_o, fail_o and steps_o are 0, the running total is cleared and the sequence value is loaded with the seed 0xB8820C7BD387E32C.
- R3: One advance step shifts the value left by one bit with a 0 entering at bit 0. If bit 63 was 1 before the shift, the result is XORed with 0x231DCEE91262B8A3.
- R4: At each step, the number of buffer words at addresses 1 to 7 that equal the current value is added to the running total, and this total carries across steps. The word at address 0 is never compared.
- R5: The goal check (running total of 6 or more) is made after the step's matches are added and before the value is advanced. When the goal is met, pass_o goes to 1, busy_o goes to 0, and steps_o holds the number of steps made, counting the passing step.
- R6: When STEP_LIMIT steps complete without the goal being met, fail_o goes to 1, busy_o goes to 0 and steps_o equals STEP_LIMIT. If the goal is met on the last allowed step, the result is a pass.
- R7: pass_o and fail_o are never both 1. Each keeps its value while the block is idle, until the next accepted start clears it.
- R8: When wr_en_i is 1 and the block is idle, wr_data_i is stored at buffer address wr_addr_i. A write while busy_o is 1 has no effect.
- R9: A start_i pulse while busy_o is 1 is ignored, and the running check goes on unchanged.
- R10: Each step takes exactly one clock cycle. busy_o stays high for exactly as many cycles as the final steps_o value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Buffer write enable |
| wr_addr_i | input | 3 | Buffer word address |
| wr_data_i | input | 64 | Buffer write data |
| start_i | input | 1 | Start strobe |
| busy_o | output | 1 | Check in progress |
| pass_o | output | 1 | Goal reached (sticky) |
| fail_o | output | 1 | Step limit exhausted (sticky) |
| steps_o | output | 16 | Comparison steps made |

## Verification
The bench fills words 1 to 7 with one sequence value and sweeps its position across every step of a reduced step limit. This separates a correct advance function and step count from off-by-one errors, including the pass-versus-fail decision on the last step. Mixed buffers spread the matches over several sequence positions, which shows whether the total really accumulates across steps. A buffer whose word 0 holds a matching value shows whether word 0 is wrongly included. An all-zero buffer and a buffer with only five hits exercise the fail path. Starts and writes injected mid-run must leave the result identical to a clean run.

// File: rtl/lfsr_match_pkg.sv
package lfsr_match_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned BUF_DEPTH  = 8;
  localparam logic [63:0] SEED_DEF   = 64'hB8820C7BD387E32C;
  localparam logic [63:0] POLY_DEF   = 64'h231DCEE91262B8A3;
  localparam int unsigned GOAL_DEF   = 6;
  localparam int unsigned LIMIT_DEF  = 40000;
endpackage

// File: rtl/lfsr_match_buffer.sv
module lfsr_match_buffer #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [WORD_W-1:0]             data_i,
  output logic [DEPTH-1:0][WORD_W-1:0]  words_o
);
  logic [DEPTH-1:0][WORD_W-1:0] mem_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (we_i && (addr_i == ADDR_W'(g)))       mem_q[g] <= data_i;
    end
  end

  assign words_o = mem_q;

  a_r8_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/lfsr_match_counter.sv
module lfsr_match_counter #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0][WORD_W-1:0] words_i,
  input  logic [WORD_W-1:0]            value_i,
  output logic [CNT_W-1:0]             count_o
);
  logic [DEPTH-1:0] hit;

  assign hit[0] = 1'b0;  // word 0 is excluded from comparison
  for (genvar g = 1; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = (words_i[g] == value_i);
  end

  always_comb begin
    count_o = '0;
    for (int i = 1; i < DEPTH; i++) count_o = count_o + CNT_W'(hit[i]);
  end
endmodule

// File: rtl/lfsr_match_stepper.sv
module lfsr_match_stepper #(
  parameter int unsigned WORD_W = 64,
  parameter logic [WORD_W-1:0] POLY = '1
) (
  input  logic [WORD_W-1:0] cur_i,
  output logic [WORD_W-1:0] nxt_o
);
  assign nxt_o = {cur_i[WORD_W-2:0], 1'b0} ^ (cur_i[WORD_W-1] ? POLY : '0);
endmodule

// File: rtl/lfsr_selftest_matcher.sv
module lfsr_selftest_matcher
  import lfsr_match_pkg::*;
#(
  parameter int unsigned STEP_LIMIT = LIMIT_DEF,
  parameter int unsigned GOAL       = GOAL_DEF,
  localparam int unsigned ADDR_W    = $clog2(BUF_DEPTH),
  localparam int unsigned STEP_W    = $clog2(STEP_LIMIT + 1),
  localparam int unsigned CNT_W     = $clog2(BUF_DEPTH),
  localparam int unsigned TOT_W     = $clog2(GOAL + BUF_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [STEP_W-1:0] steps_o
);
  logic                              busy_q, pass_q, fail_q;
  logic [WORD_W-1:0]                 value_q, value_nxt;
  logic [TOT_W-1:0]                  total_q, total_nxt;
  logic [STEP_W-1:0]                 steps_q, steps_nxt;
  logic [CNT_W-1:0]                  hits;
  logic [BUF_DEPTH-1:0][WORD_W-1:0]  words;
  logic                              start_ok, goal_met, limit_hit;

  assign start_ok = start_i && !busy_q;

  lfsr_match_buffer #(.WORD_W(WORD_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && !busy_q),
    .addr_i  (wr_addr_i),
    .data_i  (wr_data_i),
    .words_o (words)
  );

  lfsr_match_counter #(.WORD_W(WORD_W), .DEPTH(BUF_DEPTH)) u_cnt (
    .words_i (words),
    .value_i (value_q),
    .count_o (hits)
  );

  lfsr_match_stepper #(.WORD_W(WORD_W), .POLY(POLY_DEF)) u_step (
    .cur_i (value_q),
    .nxt_o (value_nxt)
  );

  assign total_nxt = total_q + TOT_W'(hits);
  assign steps_nxt = steps_q + 1'b1;
  assign goal_met  = total_nxt >= TOT_W'(GOAL);
  assign limit_hit = steps_nxt == STEP_W'(STEP_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      value_q <= '0;
      total_q <= '0;
      steps_q <= '0;
    end else if (start_ok) begin
      busy_q  <= 1'b1;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
      value_q <= SEED_DEF;
      total_q <= '0;
      steps_q <= '0;
    end else if (busy_q) begin
      steps_q <= steps_nxt;
      total_q <= total_nxt;
      if (goal_met) begin
        pass_q <= 1'b1;
        busy_q <= 1'b0;
      end else if (limit_hit) begin
        fail_q <= 1'b1;
        busy_q <= 1'b0;
      end else begin
        value_q <= value_nxt;
      end
    end
  end

  assign busy_o  = busy_q;
  assign pass_o  = pass_q;
  assign fail_o  = fail_q;
  assign steps_o = steps_q;

  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_q && fail_q));
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> (busy_q && !pass_q && !fail_q && steps_q == '0));
  a_r5_done_has_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> (pass_q ^ fail_q));
  a_r6_steps_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    steps_q <= STEP_W'(STEP_LIMIT));
  a_r7_sticky_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> ($stable(pass_q) && $stable(fail_q) && $stable(steps_q)));
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> (steps_q != '0));
  a_r10_one_step_per_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i) |=> (steps_q == $past(steps_q) + 1'b1));
endmodule

// File: tb/lfsr_selftest_matcher_test.sv
module lfsr_selftest_matcher_test;
  localparam int LIM  = 64;
  localparam int GOAL = 6;
  localparam logic [63:0] SEED = 64'hB8820C7BD387E32C;
  localparam logic [63:0] POLY = 64'h231DCEE91262B8A3;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        start_i = 1'b0;
  logic        busy_o, pass_o, fail_o;
  logic [6:0]  steps_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] bufm [8];

  always #4 clk_i = ~clk_i;

  lfsr_selftest_matcher #(.STEP_LIMIT(LIM), .GOAL(GOAL)) uut (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .start_i, .busy_o, .pass_o, .fail_o, .steps_o
  );

  function automatic logic [63:0] adv(input logic [63:0] x);
    return x[63] ? ((x << 1) ^ POLY) : (x << 1);
  endfunction

  function automatic logic [63:0] seq_at(input int n);
    logic [63:0] v = SEED;
    for (int i = 0; i < n; i++) v = adv(v);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model(output int st, output bit ps);
    logic [63:0] v = SEED;
    int tot = 0;
    for (int s = 1; s <= LIM; s++) begin
      for (int i = 1; i < 8; i++) if (bufm[i] == v) tot++;
      if (tot >= GOAL) begin st = s; ps = 1; return; end
      v = adv(v);
    end
    st = LIM; ps = 0;
  endtask

  task automatic load_buf();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      wr_en_i = 1'b1; wr_addr_i = 3'(i); wr_data_i = bufm[i];
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // inject: 0 none, 1 start mid-run, 2 write mid-run
  task automatic run_chk(input string req, input int inject);
    int st, cyc;
    bit ps;
    model(st, ps);
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o && !pass_o && !fail_o && steps_o == 0, "R2", "start state",
        {busy_o, pass_o, fail_o}, 3'b100);
    cyc = 0;
    while (busy_o && cyc < LIM + 4) begin
      if (cyc == 1 && inject == 1) start_i = 1'b1;
      if (cyc == 1 && inject == 2) begin
        wr_en_i = 1'b1; wr_addr_i = 3'd1; wr_data_i = seq_at(0);
      end
      @(negedge clk_i);
      start_i = 1'b0; wr_en_i = 1'b0;
      cyc++;
    end
    chk(pass_o == ps && fail_o == !ps, req, "verdict pass", pass_o, ps);
    chk(steps_o == st, req, "steps", steps_o, st);
    chk(cyc == st, "R10", "busy cycles", cyc, st);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    int st; bit ps;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !pass_o && !fail_o, "R1", "reset flags",
        {busy_o, pass_o, fail_o}, 0);
    chk(steps_o == 0, "R1", "reset steps", steps_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1: buffer resets to zero -> an unloaded run fails (seed sequence never 0)
    run_chk("R1", 0);
    chk(fail_o && steps_o == LIM, "R6", "fail at limit", steps_o, LIM);

    // R3 R5 R6: sweep a single value position over the whole step range
    for (int p = 0; p <= LIM; p++) begin
      logic [63:0] v = seq_at(p);
      bufm[0] = '0;
      for (int i = 1; i < 8; i++) bufm[i] = v;
      load_buf();
      run_chk(p == LIM - 1 ? "R6" : "R3", 0);
    end

    // R4: accumulation across steps
    bufm[0] = '0;
    for (int i = 1; i < 4; i++) bufm[i] = seq_at(2);
    for (int i = 4; i < 7; i++) bufm[i] = seq_at(9);
    bufm[7] = seq_at(30);
    load_buf();
    run_chk("R4", 0);
    chk(steps_o == 10, "R4", "accumulated pass step", steps_o, 10);

    // R4: word 0 never compared
    bufm[0] = seq_at(1);
    for (int i = 1; i < 6; i++) bufm[i] = seq_at(1);
    bufm[6] = seq_at(12); bufm[7] = '0;
    load_buf();
    run_chk("R4", 0);
    chk(steps_o == 13, "R4", "word0 excluded", steps_o, 13);

    // R5: only five hits in total -> fail
    bufm[0] = '0;
    for (int i = 1; i < 6; i++) bufm[i] = seq_at(4);
    bufm[6] = 64'h1; bufm[7] = 64'h2;
    load_buf();
    run_chk("R5", 0);
    chk(fail_o && !pass_o, "R5", "five hits fail", fail_o, 1);

    // R9 and R8: disturbances mid-run
    bufm[0] = '0;
    for (int i = 1; i < 7; i++) bufm[i] = seq_at(20);
    bufm[7] = 64'h5;
    load_buf();
    run_chk("R9", 1);
    run_chk("R8", 2);
    run_chk("R8", 0);
    model(st, ps);
    chk(steps_o == st, "R8", "buffer unchanged after busy write", steps_o, st);

    // R7: sticky while idle
    repeat (5) @(negedge clk_i);
    chk(pass_o && !fail_o && steps_o == 21, "R7", "sticky pass", steps_o, 21);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule